// File: doc/BRIEF.md
# SPI Register Front End with Word FIFOs

This block sits between a simple memory-mapped register bus and a serial shifter. Software programs two 32-bit control words and reads back a status word. Transmit words are queued in a small FIFO, and receive words are collected in a second FIFO. Each transmit word carries one tag bit. The tag tells the shifter whether to hold the chip select after the word or to release it. The tag is set by which of the two data addresses the word was written to.

Towards the shifter the block offers a valid/ready word stream in each direction. It also drives both control words out unchanged, so the shifter can decode speed, polarity, length and timing fields from them. The shifter reports its busy flag and current bit count, and these appear in the status word. One level interrupt is raised from two enable bits. One enable watches for an empty transmit queue. The other watches for the link being idle.

The bus has one access per cycle. Read data is registered and appears on the cycle after the read strobe. Reading the data address pops the receive FIFO. Reading the peek address returns the same head word without popping it.

Top module: `spi_reg_frontend`

## Requirements
- R1: After reset both control words read 0, both FIFOs are empty, `tx_valid` and `irq` are low, and the status word reads 0x0000_0280 when `shf_busy` and `shf_bitcnt` are 0.
- R2: A write to offset 0x00 (main control) or 0x04 (auxiliary control) is stored and shows on `cfg_main` / `cfg_aux` after the write edge. A read of either offset returns the stored value on the cycle after the read strobe. Bit 9 of the main control word is never stored and always reads 0.
- R3: A write to offset 0x20 queues the word with `tx_hold`=0, and a write to offset 0x30 queues it with `tx_hold`=1. Words leave on `tx_word` in write order, and one word is removed per cycle in which `tx_valid` and `tx_ready` are both high.
- R4: The transmit FIFO holds 4 words. A data write while it holds 4 words is dropped and leaves the queue unchanged.
- R5: A read of offset 0x20 returns the receive head and removes it. When the receive FIFO is empty, such a read returns 0 and changes nothing.
- R6: A read of offset 0x0C returns the receive head without removing it, or 0 when the receive FIFO is empty.
- R7: `rx_ready` is high exactly while the receive FIFO holds fewer than 4 words. A word offered with `rx_valid` while it is low is discarded.
- R8: The status word at 0x08 holds the TX level in bits 31:24 and the RX level in bits 23:16. Bit 10 is TX full, bit 9 TX empty, bit 8 RX full, bit 7 RX empty, bit 6 is `shf_busy`, and bits 5:0 are `shf_bitcnt`. All other bits read 0.
- R9: A write to offset 0x00 with bit 9 set empties both FIFOs at that edge.
- R10: `irq` is registered. One cycle after any state, it is high if that state meets either condition: auxiliary bit 7 is set and the TX FIFO is empty, or auxiliary bit 6 is set with the TX FIFO empty and `shf_busy` low. Writing 0 to the auxiliary word therefore silences it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| tx_valid | output | 1 | Transmit FIFO has a word for the shifter |
| tx_ready | input | 1 | Shifter accepts the presented word |
| tx_word | output | 32 | Transmit head word |
| tx_hold | output | 1 | 1: keep chip select after this word, 0: release it |
| rx_valid | input | 1 | Shifter offers a received word |
| rx_ready | output | 1 | Receive FIFO can take a word |
| rx_word | input | 32 | Received word |
| shf_busy | input | 1 | Shifter is busy |
| shf_bitcnt | input | 6 | Shifter bit count |
| cfg_main | output | 32 | Main control word, for the shifter to decode |
| cfg_aux | output | 32 | Auxiliary control word, for the shifter to decode |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the shifter obeys the stream handshake. It never pulls `tx_ready` for a word that is not valid in a way that matters, and it holds `rx_word` only for the cycles it asserts `rx_valid`. The stall-stability property also assumes that nothing but a clear-bit write removes a stalled head word. The bench drives one bus access per cycle and never raises a read and a write together. It drives the shifter side only through handshake tasks that raise `tx_ready` or `rx_valid` for exactly one cycle. This keeps every stimulus, random or directed, inside those assumptions.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 32;

  // register offsets; the shifter-facing software map depends on these
  localparam logic [ADDR_W-1:0] OFS_MAIN = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_AUX  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_PEEK = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_HOLD = 6'h30;

  // control bit positions used inside this block
  localparam int BIT_FLUSH    = 9;
  localparam int BIT_IRQ_TXE  = 7;
  localparam int BIT_IRQ_IDLE = 6;

  typedef struct packed {
    logic [7:0] tx_lvl;
    logic [7:0] rx_lvl;
    logic [4:0] zero;
    logic       tx_full;
    logic       tx_empty;
    logic       rx_full;
    logic       rx_empty;
    logic       busy;
    logic [5:0] bitcnt;
  } stat_t;
endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp];
  assign count   = cnt;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R4 (transmit side) and R7 (receive side): a full queue refuses a push
  a_r4_full_no_write: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (count == CNT_W'(DEPTH)));

  // R5: popping an empty queue leaves it empty
  a_r5_empty_pop_stays: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (count == '0));

  // R9: a clear empties the queue on the next cycle
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/spi_fe_irq.sv
module spi_fe_irq (
  input  logic clk,
  input  logic rst,
  input  logic en_txe,
  input  logic en_idle,
  input  logic tx_empty,
  input  logic busy,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= tx_empty && (en_txe || (en_idle && !busy));
  end

  // R10: an enabled empty queue raises the line one cycle later
  a_r10_txe_raises: assert property (@(posedge clk) disable iff (rst)
    (en_txe && tx_empty) |=> irq);

  // R10: a non-empty queue keeps the line low
  a_r10_busy_queue_low: assert property (@(posedge clk) disable iff (rst)
    !tx_empty |=> !irq);
endmodule

// File: rtl/spi_reg_frontend.sv
module spi_reg_frontend
  import spi_fe_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_hold,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              shf_busy,
  input  logic [5:0]        shf_bitcnt,
  output logic [WORD_W-1:0] cfg_main,
  output logic [WORD_W-1:0] cfg_aux,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [WORD_W-1:0] FLUSH_MASK = WORD_W'(1) << BIT_FLUSH;

  logic [WORD_W-1:0] main_q, aux_q;
  logic wr_main, wr_aux, wr_data, wr_hold, rd_pop, flush;

  always_comb begin
    wr_main = bus_wr && (bus_addr == OFS_MAIN);
    wr_aux  = bus_wr && (bus_addr == OFS_AUX);
    wr_data = bus_wr && (bus_addr == OFS_DATA);
    wr_hold = bus_wr && (bus_addr == OFS_HOLD);
    rd_pop  = bus_rd && (bus_addr == OFS_DATA);
    flush   = wr_main && bus_wdata[BIT_FLUSH];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= '0;
      aux_q  <= '0;
    end else begin
      if (wr_main) main_q <= bus_wdata & ~FLUSH_MASK;
      if (wr_aux)  aux_q  <= bus_wdata;
    end
  end

  assign cfg_main = main_q;
  assign cfg_aux  = aux_q;

  // transmit queue: tag bit sits above the data word
  logic [WORD_W:0]    tx_head;
  logic [CNT_W-1:0]   tx_cnt;
  logic               tx_full, tx_empty;

  spi_fe_fifo #(.WIDTH(WORD_W + 1), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .clr   (flush),
    .push  (wr_data || wr_hold),
    .din   ({wr_hold, bus_wdata}),
    .pop   (tx_valid && tx_ready),
    .dout  (tx_head),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty)
  );

  assign tx_valid = !tx_empty;
  assign tx_word  = tx_empty ? '0 : tx_head[WORD_W-1:0];
  assign tx_hold  = !tx_empty && tx_head[WORD_W];

  // receive queue
  logic [WORD_W-1:0]  rx_head;
  logic [CNT_W-1:0]   rx_cnt;
  logic               rx_full, rx_empty;

  spi_fe_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .clr   (flush),
    .push  (rx_valid && rx_ready),
    .din   (rx_word),
    .pop   (rd_pop),
    .dout  (rx_head),
    .count (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty)
  );

  assign rx_ready = !rx_full;

  stat_t stat;
  always_comb begin
    stat          = '0;
    stat.tx_lvl   = 8'(tx_cnt);
    stat.rx_lvl   = 8'(rx_cnt);
    stat.tx_full  = tx_full;
    stat.tx_empty = tx_empty;
    stat.rx_full  = rx_full;
    stat.rx_empty = rx_empty;
    stat.busy     = shf_busy;
    stat.bitcnt   = shf_bitcnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_MAIN:           bus_rdata <= main_q;
        OFS_AUX:            bus_rdata <= aux_q;
        OFS_STAT:           bus_rdata <= stat;
        OFS_PEEK, OFS_DATA: bus_rdata <= rx_empty ? '0 : rx_head;
        default:            bus_rdata <= '0;
      endcase
    end
  end

  spi_fe_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .en_txe   (aux_q[BIT_IRQ_TXE]),
    .en_idle  (aux_q[BIT_IRQ_IDLE]),
    .tx_empty (tx_empty),
    .busy     (shf_busy),
    .irq      (irq)
  );

  // R3: a stalled head word stays on the stream unless a flush removes it
  a_r3_stall_holds_word: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !flush) |=> (tx_valid && $stable(tx_word) && $stable(tx_hold)));

  // R7: a full receive queue keeps its level while a word is offered
  a_r7_full_rx_refuses: assert property (@(posedge clk) disable iff (rst)
    (rx_full && rx_valid && !rd_pop && !flush) |=> (rx_cnt == CNT_W'(DEPTH)));
endmodule

// File: tb/tb_spi_reg_frontend.sv
module tb_spi_reg_frontend;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0, tx_hold;
  logic [31:0] tx_word;
  logic        rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_word = '0;
  logic        shf_busy = 1'b0;
  logic [5:0]  shf_bitcnt = '0;
  logic [31:0] cfg_main, cfg_aux;
  logic        irq;

  always #2 clk = ~clk;  // 250 MHz

  spi_reg_frontend dut (.*);

  int checks = 0, errors = 0;
  logic [32:0] mtx[$];
  logic [31:0] mrx[$];
  logic [31:0] m_main = '0, m_aux = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] want);
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, want);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    int t = mtx.size(), r = mrx.size();
    return {8'(t), 8'(r), 5'b0, t == 4, t == 0, r == 4, r == 0, shf_busy, shf_bitcnt};
  endfunction

  function automatic logic exp_irq();
    return (mtx.size() == 0) && (m_aux[7] || (m_aux[6] && !shf_busy));
  endfunction

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    if (a == 6'h00) begin
      m_main = d & ~32'h200;
      if (d[9]) begin mtx.delete(); mrx.delete(); end
    end else if (a == 6'h04) m_aux = d;
    else if ((a == 6'h20 || a == 6'h30) && mtx.size() < 4) mtx.push_back({a == 6'h30, d});
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    if (a == 6'h20 && mrx.size() > 0) void'(mrx.pop_front());
  endtask

  task automatic rd_check(input string req, input logic [5:0] a);
    logic [31:0] want, got;
    case (a)
      6'h00: want = m_main;
      6'h04: want = m_aux;
      6'h08: want = exp_stat();
      6'h0C, 6'h20: want = (mrx.size() > 0) ? mrx[0] : 32'h0;
      default: want = 32'h0;
    endcase
    bus_read(a, got);
    chk(req, got, want);
  endtask

  task automatic take_tx();
    if (mtx.size() > 0) begin
      chk("R3 valid", 32'(tx_valid), 32'd1);
      chk("R3 word", tx_word, mtx[0][31:0]);
      chk("R3 hold tag", 32'(tx_hold), 32'(mtx[0][32]));
      tx_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      tx_ready = 1'b0;
      void'(mtx.pop_front());
    end else begin
      chk("R3 no valid when empty", 32'(tx_valid), 32'd0);
    end
  endtask

  task automatic push_rx(input logic [31:0] d);
    chk("R7 rx_ready", 32'(rx_ready), 32'(mrx.size() < 4));
    rx_valid = 1'b1; rx_word = d;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
    if (mrx.size() < 4) mrx.push_back(d);
  endtask

  task automatic irq_check();
    @(posedge clk); @(negedge clk);
    chk("R10 irq", 32'(irq), 32'(exp_irq()));
    chk("R2 cfg_main", cfg_main, m_main);
    chk("R2 cfg_aux", cfg_aux, m_aux);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 cfg_main", cfg_main, 32'h0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);
    rd_check("R1 status", 6'h08);
    rd_check("R1 main", 6'h00);

    // R2 control words, flush bit never stored
    bus_write(6'h00, 32'hFFF4_4BFF);
    rd_check("R2 main readback", 6'h00);
    bus_write(6'h04, 32'h0000_0703);
    rd_check("R2 aux readback", 6'h04);
    irq_check();

    // R3/R4 fill with mixed tags, fifth write dropped
    bus_write(6'h20, 32'h1111_0001);
    bus_write(6'h30, 32'h2222_0002);
    bus_write(6'h30, 32'h3333_0003);
    bus_write(6'h20, 32'h4444_0004);
    bus_write(6'h30, 32'hDEAD_BEEF);
    rd_check("R4 status full", 6'h08);
    chk("R4 four queued", 32'(mtx.size()), 32'd4);
    repeat (5) take_tx();

    // R7 receive side, fifth word dropped; R6 peek twice
    for (int i = 0; i < 5; i++) push_rx(32'hA000_0000 + i);
    rd_check("R8 status rx full", 6'h08);
    rd_check("R6 peek", 6'h0C);
    rd_check("R6 peek again", 6'h0C);
    for (int i = 0; i < 5; i++) rd_check("R5 pop", 6'h20);
    rd_check("R5 empty status", 6'h08);

    // R9 flush both queues
    bus_write(6'h20, 32'h5);
    push_rx(32'h6);
    bus_write(6'h00, 32'h0000_0200);
    rd_check("R9 status after flush", 6'h08);
    rd_check("R2 flush bit reads 0", 6'h00);

    // R10 enables and busy
    bus_write(6'h04, 32'h40); shf_busy = 1'b1; irq_check();
    shf_busy = 1'b0; irq_check();
    bus_write(6'h20, 32'h7); irq_check();
    take_tx(); bus_write(6'h04, 32'h0); irq_check();

    // R8 busy and bit count pass through
    shf_busy = 1'b1; shf_bitcnt = 6'd37;
    rd_check("R8 status fields", 6'h08);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 11);
      case (op)
        0, 1: bus_write(6'h20, $urandom());
        2:    bus_write(6'h30, $urandom());
        3:    take_tx();
        4:    push_rx($urandom());
        5:    rd_check("R5 random pop", 6'h20);
        6:    rd_check("R6 random peek", 6'h0C);
        7:    rd_check("R8 random status", 6'h08);
        8:    bus_write(6'h04, $urandom() & 32'h7C3);
        9:    begin shf_busy = $urandom_range(0, 1); shf_bitcnt = 6'($urandom()); irq_check(); end
        10:   bus_write(6'h00, ($urandom_range(0, 7) == 0) ? 32'h200 : ($urandom() & ~32'h200));
        default: irq_check();
      endcase
    end
    irq_check();
    finish_run();
  end
endmodule